// File: doc/BRIEF.md
# I2C Two-Channel Bus Switch Controller

This block is the digital control side of a two-channel I2C bus switch. It acts as an I2C target on an upstream bus. It oversamples SCL and SDA on a fast system clock and recovers START, STOP, address, data and acknowledge bits from those samples. It answers on SDA through one open-drain pull-down enable. A host writes a control byte that chooses which of two downstream channels are connected. The host can read the same byte back, and the byte it reads also carries the live state of two active-low interrupt lines from the downstream side.

The two channel-enable outputs are meant to drive external pass gates. A new selection reaches those outputs only when the host ends the transaction with a STOP, so a channel is never connected in the middle of a transfer. An active-low reset clears the selection and returns the bus logic to idle.

The block has no streaming data path. Every pin is a plain level signal, so no valid/ready handshake is used.

Top module: `i2csw_top`

## Requirements
- R1: The block answers to the 7-bit address formed by the fixed bits 11100 followed by addr_strap[1] and then addr_strap[0]. The bit after the address selects the direction: 1 is a read and 0 is a write. A matching address is acknowledged by driving SDA low during the ninth clock. A non-matching address is not acknowledged, and the block keeps off SDA until the next START or STOP.
- R2: In a write, every data byte that follows the address is acknowledged. When several data bytes arrive in one transaction, only the last one is kept.
- R3: Control bit 0 selects channel 0 (chan_en[0]) and control bit 1 selects channel 1 (chan_en[1]). Any combination is allowed, including both channels and neither. Bits 7:2 of a written byte are ignored.
- R4: chan_en changes only when a STOP condition is detected. A byte that has been written but not yet followed by a STOP leaves chan_en unchanged.
- R5: A read returns the byte {2'b00, int1, int0, 2'b00, sel1, sel0}. Here sel1 and sel0 are the stored selection bits. int1 is 1 when irq_n[1] is low and int0 is 1 when irq_n[0] is low. These two bits are sampled when the byte is loaded for transmission.
- R6: During a read, each master acknowledge makes the block send the byte again. A master NACK ends the transfer: the block releases SDA and stays off the bus until the next START or STOP.
- R7: While rst_n is low, the stored selection and chan_en are 0 and SDA is released. After rst_n returns high, a read returns a selection of 00.
- R8: A repeated START, seen at any point of a transaction, restarts address reception. This lets a write be followed by a read without a STOP in between.
- R9: sda_drive_low changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset (power-on or external) |
| scl_in | input | 1 | Sampled level of the upstream SCL line |
| sda_in | input | 1 | Sampled level of the upstream SDA line |
| addr_strap | input | 2 | Address strap bits; bit 1 is the sixth address bit and bit 0 the seventh |
| irq_n | input | 2 | Active-low interrupt lines from downstream channels 1 and 0 |
| sda_drive_low | output | 1 | When high, the open-drain stage pulls SDA low |
| chan_en | output | 2 | Channel enables for the pass gates; bit n connects channel n |

## Verification
The assertions assume that SCL stays low for well over the synchroniser latency of three system clocks after each falling edge. They also assume that SDA changes only while SCL is low, except for START and STOP. The bench master keeps within both: each half bit lasts ten system clocks, and SDA is moved five clocks after SCL falls. The interrupt lines are changed only while the bus is idle, so each sampled status bit has a single expected value.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
  localparam int BYTE_W = 8;
  localparam int NCH = 2;
  localparam int IRQ_LSB = 4;
  localparam logic [4:0] FIXED_ADDR = 5'b11100;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ACK,
    S_WDATA,
    S_RDATA,
    S_RACK,
    S_IGNORE
  } bus_state_t;
endpackage

// File: rtl/i2csw_sync.sv
module i2csw_sync #(
  parameter int N = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2csw_ctrl.sv
module i2csw_ctrl
  import i2csw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              stop_evt,
  input  logic [NCH-1:0]    irq_s_n,
  output logic [NCH-1:0]    chan_en,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [NCH-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      chan_en <= '0;
    end else begin
      if (wr_strobe) sel_q <= wr_byte[NCH-1:0];
      if (stop_evt)  chan_en <= sel_q;
    end
  end

  always_comb begin
    rd_byte = '0;
    rd_byte[NCH-1:0] = sel_q;
    rd_byte[IRQ_LSB +: NCH] = ~irq_s_n;
  end

  // R4: enables move only on the cycle after a STOP
  assert_apply_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en != $past(chan_en)) |-> $past(stop_evt));
endmodule

// File: rtl/i2csw_link.sv
module i2csw_link
  import i2csw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [1:0]        addr_strap,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              drive_low,
  output logic              wr_strobe,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              stop_evt
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] ALL_BITS = CW'(BYTE_W);

  bus_state_t        state;
  logic              scl_q, sda_q;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              is_read, ack_phase, master_ack;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [6:0]        my_addr;

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign stop_evt = stop_c;
  assign my_addr  = {FIXED_ADDR, addr_strap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      is_read    <= 1'b0;
      ack_phase  <= 1'b0;
      master_ack <= 1'b0;
      drive_low  <= 1'b0;
      wr_strobe  <= 1'b0;
      wr_byte    <= '0;
    end else begin
      wr_strobe <= 1'b0;
      if (start_c) begin
        state     <= S_ADDR;
        cnt       <= '0;
        drive_low <= 1'b0;
        ack_phase <= 1'b0;
      end else if (stop_c) begin
        state     <= S_IDLE;
        drive_low <= 1'b0;
      end else begin
        case (state)
          S_ADDR: if (scl_rise) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              if (rx_sh[6:0] == my_addr) begin
                state     <= S_ACK;
                is_read   <= sda_s;
                ack_phase <= 1'b0;
              end else begin
                state <= S_IGNORE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ACK: if (scl_fall) begin
            if (!ack_phase) begin
              drive_low <= 1'b1;
              ack_phase <= 1'b1;
            end else begin
              ack_phase <= 1'b0;
              cnt       <= '0;
              if (is_read) begin
                tx_sh     <= rd_byte;
                drive_low <= ~rd_byte[BYTE_W-1];
                state     <= S_RDATA;
              end else begin
                drive_low <= 1'b0;
                state     <= S_WDATA;
              end
            end
          end
          S_WDATA: if (scl_rise) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
            if (cnt == LAST_BIT) begin
              wr_strobe <= 1'b1;
              wr_byte   <= {rx_sh[BYTE_W-2:0], sda_s};
              cnt       <= '0;
              ack_phase <= 1'b0;
              state     <= S_ACK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RDATA: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == ALL_BITS) begin
                drive_low <= 1'b0;
                state     <= S_RACK;
              end else begin
                tx_sh     <= {tx_sh[BYTE_W-2:0], 1'b0};
                drive_low <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) master_ack <= ~sda_s;
            else if (scl_fall) begin
              if (master_ack) begin
                tx_sh     <= rd_byte;
                drive_low <= ~rd_byte[BYTE_W-1];
                cnt       <= '0;
                state     <= S_RDATA;
              end else begin
                state <= S_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the pull-down only moves while the sampled clock is low
  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_low != $past(drive_low)) |-> !scl_s);

  // R1: a non-addressed target never touches the bus
  assert_ignore_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IGNORE) |-> !drive_low);

  // R6: a master NACK ends the read with SDA released
  assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RACK && scl_fall && !master_ack && !start_c && !stop_c)
      |=> (state == S_IGNORE && !drive_low));

  // R8: a START always restarts address reception
  assert_restart_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == S_ADDR && cnt == '0));
endmodule

// File: rtl/i2csw_top.sv
module i2csw_top
  import i2csw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_in,
  input  logic           sda_in,
  input  logic [1:0]     addr_strap,
  input  logic [NCH-1:0] irq_n,
  output logic           sda_drive_low,
  output logic [NCH-1:0] chan_en
);
  logic [1:0]        bus_s;
  logic [NCH-1:0]    irq_s_n;
  logic              wr_strobe, stop_evt;
  logic [BYTE_W-1:0] wr_byte, rd_byte;

  i2csw_sync #(.N(2), .STAGES(2)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_in, scl_in}), .q(bus_s));

  i2csw_sync #(.N(NCH), .STAGES(2)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_n), .q(irq_s_n));

  i2csw_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[0]), .sda_s(bus_s[1]),
    .addr_strap(addr_strap), .rd_byte(rd_byte), .drive_low(sda_drive_low),
    .wr_strobe(wr_strobe), .wr_byte(wr_byte), .stop_evt(stop_evt));

  i2csw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_byte(wr_byte),
    .stop_evt(stop_evt), .irq_s_n(irq_s_n), .chan_en(chan_en),
    .rd_byte(rd_byte));
endmodule

// File: tb/sim_i2csw_top.sv
`timescale 1ns/1ps
module sim_i2csw_top;
  localparam int Q = 5;
  localparam logic [19:0] VECS [6] = '{
    {2'b11, 8'h01, 2'b01, 8'h01},
    {2'b10, 8'h02, 2'b10, 8'h12},
    {2'b01, 8'h03, 2'b11, 8'h23},
    {2'b00, 8'hFC, 2'b00, 8'h30},
    {2'b11, 8'hCD, 2'b01, 8'h01},
    {2'b00, 8'h26, 2'b10, 8'h32}
  };

  logic clk = 0, rst_n = 0, m_scl = 1, m_sda = 1;
  logic [1:0] addr_strap = 2'b01, irq_n = 2'b11;
  logic sda_drive_low, sda_line, prev_drive;
  logic [1:0] chan_en;
  int nvec = 0, nfail = 0, viol = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_drive_low;

  i2csw_top u0 (.clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .addr_strap(addr_strap), .irq_n(irq_n), .sda_drive_low(sda_drive_low),
    .chan_en(chan_en));

  always @(negedge clk) begin
    if (rst_n && sda_drive_low !== prev_drive && m_scl) viol++;
    prev_drive = sda_drive_low;
  end

  task automatic check(input string req, input logic [7:0] act, exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic i2c_start;
    m_sda = 1; wq; m_scl = 1; wq; m_sda = 0; wq; m_scl = 0; wq;
  endtask
  task automatic i2c_stop;
    m_sda = 0; wq; m_scl = 1; wq; m_sda = 1; wq; wq;
  endtask
  task automatic bit_x(input logic b, output logic r);
    m_sda = b; wq; m_scl = 1; wq; r = sda_line; wq; m_scl = 0; wq;
  endtask
  task automatic byte_w(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(d[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask
  task automatic byte_r(input logic m_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, r); d[i] = r; end
    bit_x(~m_ack, r);
  endtask
  task automatic write_reg(input logic [6:0] a, input logic [7:0] d, output logic a1, a2);
    i2c_start; byte_w({a, 1'b0}, a1); byte_w(d, a2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic a1, a2;
    logic [7:0] rd, rd2;
    repeat (4) @(negedge clk);
    check("R7 reset chan_en", {6'd0, chan_en}, 8'h00);
    check("R7 reset drive", {7'd0, sda_drive_low}, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      irq_n = VECS[v][19:18];
      wq;
      write_reg(7'h71, VECS[v][17:10], a1, a2);
      check("R1 address ack", {7'd0, a1}, 8'h01);
      check("R2 data ack", {7'd0, a2}, 8'h01);
      i2c_stop; wq;
      check("R3 channel enables", {6'd0, chan_en}, {6'd0, VECS[v][9:8]});
      i2c_start; byte_w(8'hE3, a1); byte_r(1'b0, rd); i2c_stop;
      check("R5 read byte", rd, VECS[v][7:0]);
    end

    // R4: no change before STOP
    irq_n = 2'b11;
    write_reg(7'h71, 8'h03, a1, a2);
    wq; wq;
    check("R4 held before stop", {6'd0, chan_en}, 8'h02);
    i2c_stop; wq;
    check("R4 applied at stop", {6'd0, chan_en}, 8'h03);

    // R2: last of several bytes kept
    write_reg(7'h71, 8'h01, a1, a2);
    byte_w(8'h02, a1);
    check("R2 second data ack", {7'd0, a1}, 8'h01);
    byte_w(8'h00, a1);
    i2c_stop; wq;
    check("R2 last byte kept", {6'd0, chan_en}, 8'h00);

    // R1: wrong address is ignored
    write_reg(7'h72, 8'h03, a1, a2);
    check("R1 mismatch nack", {7'd0, a1}, 8'h00);
    check("R1 mismatch data nack", {7'd0, a2}, 8'h00);
    i2c_stop; wq;
    check("R1 mismatch no effect", {6'd0, chan_en}, 8'h00);

    // R1: strap change moves the address
    addr_strap = 2'b10; wq;
    write_reg(7'h72, 8'h02, a1, a2);
    check("R1 strap address ack", {7'd0, a1}, 8'h01);
    i2c_stop; wq;
    check("R1 strap write", {6'd0, chan_en}, 8'h02);
    addr_strap = 2'b01; wq;

    // R8: repeated START into read; R6: ack then nack
    write_reg(7'h71, 8'h01, a1, a2);
    i2c_start; byte_w(8'hE3, a1);
    check("R8 restart address ack", {7'd0, a1}, 8'h01);
    byte_r(1'b1, rd); byte_r(1'b0, rd2);
    check("R8 read after restart", rd, 8'h01);
    check("R6 repeat byte after ack", rd2, 8'h01);
    wq;
    check("R6 released after nack", {7'd0, sda_drive_low}, 8'h00);
    i2c_stop; wq;
    check("R8 stop applies", {6'd0, chan_en}, 8'h01);

    // R7: reset clears selection
    write_reg(7'h71, 8'h03, a1, a2); i2c_stop; wq;
    check("R7 pre-reset", {6'd0, chan_en}, 8'h03);
    rst_n = 0; repeat (3) @(negedge clk);
    check("R7 reset clears", {6'd0, chan_en}, 8'h00);
    rst_n = 1; repeat (4) @(negedge clk);
    i2c_start; byte_w(8'hE3, a1); byte_r(1'b0, rd); i2c_stop;
    check("R7 read after reset", rd, 8'h00);

    check("R9 drive moved while SCL high", viol[7:0], 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule